// File: doc/BRIEF.md
# DMA Channel Request Router and Fixed-Priority Arbiter

This block sits in front of the transfer engine of one DMA controller block with four channels. Sixteen hardware request lines come in. Each channel owns a group of four of those lines, and a 2-bit select field per channel picks which line of its group can wake it. A rising edge on the picked line, or a one-cycle software trigger, sets a sticky pending bit for that channel.

Enabled channels that have a pending request compete by fixed priority, and channel 0 wins. The winner receives a one-hot grant and a binary index. Both stay frozen until the engine reports that the transfer is done. That done pulse acknowledges the channel and clears its pending bit. The arbiter then sits idle for one cycle and picks the next winner on the following edge.

Top module: `dma_req_arb`

## Requirements
- R1: Channel n takes hardware requests only from lines 4n to 4n+3. Its select field, bits [2n+1:2n] of `sel_i`, holding value k routes line 4n+k. The other three lines of the group have no effect on the channel.
- R2: A selected line that is high at a clock edge, after being low at the previous edge, sets the channel's pending bit. A line held high makes exactly one request. The line history resets to low.
- R3: `sw_trig_i[n]` high at a clock edge sets pending bit n.
- R4: A pending bit stays set until its channel is acknowledged. This includes the whole time the channel is disabled.
- R5: When no grant is active, the next edge grants the lowest-index channel that is both pending and enabled. A request seen at edge k gives a grant after edge k+1.
- R6: A channel whose `ch_en_i` bit is low is never given a new grant.
- R7: While `done_i` is low, an active grant and its index stay unchanged, even when new requests arrive.
- R8: `done_i` high with a grant active drops the grant at that edge and clears the granted channel's pending bit. The next arbitration happens at the following edge. If a new request for the same channel arrives at the same edge, the request wins over the clear.
- R9: `done_i` high with no grant active changes neither the pending bits nor the grants.
- R10: `grant_o` is one-hot or all zero. `grant_idx_o` is the binary index of the granted channel, or 0 when there is no grant.
- R11: Driving `rst_ni` low clears all pending bits, grants and line history at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | 16 | Hardware request lines; group n is [4n+3:4n] |
| sel_i | input | 8 | Per-channel 2-bit line select, channel n in [2n+1:2n] |
| sw_trig_i | input | 4 | Per-channel software request pulse |
| ch_en_i | input | 4 | Per-channel enable |
| done_i | input | 1 | Transfer complete / acknowledge from engine |
| grant_o | output | 4 | One-hot channel grant |
| grant_idx_o | output | 2 | Index of granted channel |

## Verification
Several properties are checked by assertions on every cycle:
- a set request is always latched, and a pending bit survives until it is acknowledged;
- a new grant goes only to an enabled channel and is one-hot;
- a grant is held until done, and done drops it;
- an acknowledge clears pending unless a new request arrives at the same edge;
- the index agrees with the grant.

Other behaviour can only be shown by the bench's scenarios:
- the exact routing of each line to its channel;
- edge detection as opposed to level detection;
- the priority order across every set of pending requests;
- delayed service of channels that were disabled and later enabled;
- the absence of any effect from an idle done pulse;
- the clearing effect of reset.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  parameter int unsigned DEF_NUM_CH = 4;
  parameter int unsigned DEF_CANDS  = 4;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dma_req_edge.sv
module dma_req_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= line_i;
  end

  assign rise_o = line_i & ~hist_q;

  // R2: a line held high yields no second rise
  p_single_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(line_i)) == '0));
endmodule

// File: rtl/dma_req_mux.sv
module dma_req_mux #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CANDS  = 4,
  localparam int unsigned SEL_W = $clog2(CANDS),
  localparam int unsigned N_REQ = NUM_CH * CANDS
) (
  input  logic [N_REQ-1:0]        rise_i,
  input  logic [NUM_CH*SEL_W-1:0] sel_i,
  output logic [NUM_CH-1:0]       hw_set_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CANDS-1:0] grp;
    logic [SEL_W-1:0] pick;
    assign grp  = rise_i[ch*CANDS +: CANDS];
    assign pick = sel_i[ch*SEL_W +: SEL_W];
    assign hw_set_o[ch] = grp[pick];
  end
endmodule

// File: rtl/dma_pend_bank.sv
module dma_pend_bank #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] pend_q;

  // set wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    p_set_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[n] |=> pend_q[n]);
    p_pend_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[n] && !clr_i[n]) |=> pend_q[n]);
    p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_q[n] && !set_i[n]) |=> !pend_q[n]);
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_CH-1:0] ack_o
);
  arb_state_e        state_q;
  logic [NUM_CH-1:0] gnt_q;
  logic [NUM_CH-1:0] pick;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) pick = NUM_CH'(1) << i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      gnt_q   <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: if (req_i != '0) begin
          gnt_q   <= pick;
          state_q <= ARB_HOLD;
        end
        ARB_HOLD: if (done_i) begin
          gnt_q   <= '0;
          state_q <= ARB_IDLE;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (gnt_q[i]) idx_o = IDX_W'(i);
    end
  end

  assign gnt_o = gnt_q;
  assign ack_o = (state_q == ARB_HOLD) ? (gnt_q & {NUM_CH{done_i}}) : '0;

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  p_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q != '0) && !done_i) |=> $stable(gnt_q));
  p_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q != '0) && done_i) |=> (gnt_q == '0));
  p_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q == '0) && (req_i != '0)) |=> $onehot(gnt_q));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    p_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gnt_q[n]) |-> $past(en_i[n]));
  end
endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CANDS  = DEF_CANDS,
  localparam int unsigned SEL_W = $clog2(CANDS),
  localparam int unsigned N_REQ = NUM_CH * CANDS,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REQ-1:0]        hw_req_i,
  input  logic [NUM_CH*SEL_W-1:0] sel_i,
  input  logic [NUM_CH-1:0]       sw_trig_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic                    done_i,
  output logic [NUM_CH-1:0]       grant_o,
  output logic [IDX_W-1:0]        grant_idx_o
);
  logic [N_REQ-1:0]  rise;
  logic [NUM_CH-1:0] hw_set;
  logic [NUM_CH-1:0] pend_set;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] ack;
  logic [NUM_CH-1:0] arb_req;

  dma_req_edge #(.W(N_REQ)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (hw_req_i),
    .rise_o (rise)
  );

  dma_req_mux #(.NUM_CH(NUM_CH), .CANDS(CANDS)) u_mux (
    .rise_i   (rise),
    .sel_i    (sel_i),
    .hw_set_o (hw_set)
  );

  assign pend_set = hw_set | sw_trig_i;

  dma_pend_bank #(.NUM_CH(NUM_CH)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pend_set),
    .clr_i  (ack),
    .pend_o (pend)
  );

  // disabled channels keep pending but do not compete
  assign arb_req = pend & ch_en_i;

  dma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (arb_req),
    .en_i   (ch_en_i),
    .done_i (done_i),
    .gnt_o  (grant_o),
    .idx_o  (grant_idx_o),
    .ack_o  (ack)
  );

  p_idx_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) ? (grant_idx_o == '0) : grant_o[grant_idx_o]);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[n] && done_i && !pend_set[n]) |=> !pend[n]);
    p_grant_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(grant_o[n]) |-> $past(pend[n]));
  end
endmodule

// File: tb/sim_dma_req_arb.sv
module sim_dma_req_arb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hw_req;
  logic [7:0]  sel;
  logic [3:0]  sw_trig;
  logic [3:0]  en;
  logic        done;
  logic [3:0]  grant;
  logic [1:0]  grant_idx;

  int errors = 0;
  int checks = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  dma_req_arb u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .hw_req_i    (hw_req),
    .sel_i       (sel),
    .sw_trig_i   (sw_trig),
    .ch_en_i     (en),
    .done_i      (done),
    .grant_o     (grant),
    .grant_idx_o (grant_idx)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_grant(input string tag, input int exp_ch);
    logic [3:0] eg;
    logic [1:0] ei;
    eg = (exp_ch < 0) ? 4'h0 : (4'h1 << exp_ch);
    ei = (exp_ch < 0) ? 2'd0 : 2'(exp_ch);
    checks++;
    if (grant !== eg || grant_idx !== ei) begin
      errors++;
      $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d",
               tag, grant, grant_idx, eg, ei);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // expects grant on ch now; acknowledges; leaves at the edge of next arbitration
  task automatic service(input string tag, input int ch);
    check_grant(tag, ch);
    done = 1'b1;
    tick();
    done = 1'b0;
    check_grant({tag, "_drop_R8"}, -1);
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hw_req = '0; sel = '0; sw_trig = '0; en = '0; done = 1'b0;
    tick(3);
    check_grant("R11_reset", -1);
    rst_n = 1'b1;
    tick();
    check_grant("R11_after_reset", -1);

    // R1 / R2: every channel, select value and candidate line
    for (int n = 0; n < 4; n++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 4; c++) begin
          en  = 4'h1 << n;
          sel = {4{2'(s)}};
          hw_req[4*n + c] = 1'b1;
          tick(2);
          if (c == s) begin
            check_grant("R1_route", n);
            done = 1'b1;
            tick();
            done = 1'b0;
            check_grant("R8_drop", -1);
            tick();
            check_grant("R2_level_once", -1);
          end else begin
            check_grant("R1_unselected", -1);
          end
          hw_req = '0;
          tick();
        end
      end
    end
    en = '0;

    // R3 / R5: every nonempty set of software requests, served in index order
    for (int m = 1; m < 16; m++) begin
      en = 4'hF;
      sw_trig = 4'(m);
      tick();
      sw_trig = '0;
      tick();
      for (int c = 0; c < 4; c++) if (m[c]) service("R5_prio", c);
      check_grant("R3_all_served", -1);
    end

    // R6 / R4: every enable mask; disabled ones wait, then are served
    for (int e = 0; e < 16; e++) begin
      en = 4'(e);
      sw_trig = 4'hF;
      tick();
      sw_trig = '0;
      tick();
      for (int c = 0; c < 4; c++) if (e[c]) service("R6_enabled", c);
      check_grant("R6_disabled_idle", -1);
      tick();
      check_grant("R6_disabled_idle2", -1);
      en = 4'hF;
      tick();
      for (int c = 0; c < 4; c++) if (!e[c]) service("R4_held", c);
      check_grant("R4_drained", -1);
    end

    // R7: higher-priority request does not preempt a held grant
    en = 4'hF;
    sw_trig = 4'h8;
    tick();
    sw_trig = '0;
    tick();
    check_grant("R7_first", 3);
    sw_trig = 4'h1;
    tick();
    sw_trig = '0;
    for (int k = 0; k < 4; k++) begin
      check_grant("R7_hold", 3);
      tick();
    end
    service("R7_hold", 3);
    service("R7_next", 0);
    check_grant("R7_end", -1);

    // R8: new request at the acknowledge edge survives
    sw_trig = 4'h2;
    tick();
    sw_trig = '0;
    tick();
    check_grant("R8_first", 1);
    done = 1'b1;
    sw_trig = 4'h2;
    tick();
    done = 1'b0;
    sw_trig = '0;
    check_grant("R8_gap", -1);
    tick();
    service("R8_set_wins", 1);
    check_grant("R8_end", -1);

    // R9: idle done leaves a disabled channel's pending bit intact
    en = 4'b1011;
    sw_trig = 4'h4;
    tick();
    sw_trig = '0;
    tick();
    check_grant("R9_no_grant", -1);
    done = 1'b1;
    tick();
    done = 1'b0;
    tick();
    check_grant("R9_still_idle", -1);
    en = 4'hF;
    tick();
    service("R9_pending_kept", 2);
    check_grant("R9_end", -1);

    // R11: reset drops a pending request
    en = '0;
    sw_trig = 4'h1;
    tick();
    sw_trig = '0;
    rst_n = 1'b0;
    #1;
    check_grant("R11_async", -1);
    tick();
    rst_n = 1'b1;
    en = 4'hF;
    tick(2);
    check_grant("R11_pending_cleared", -1);

    finish_run();
  end
endmodule